// File: doc/BRIEF.md
# Contact Card Power Sequencer and Answer-to-Reset Supervisor

This block powers a contact smart card up and down in the order the ISO 7816-3 electrical rules require. A rising edge on the host's start bit brings the card up: supply first, then the data line enabled for reception, then the card clock, and finally reset released after a programmable hold counted in card clock cycles. Once reset is released, the block times the card's answer-to-reset in card clock ticks. The answer is taken as the first falling edge of the card data line. The answer is marked early when it arrives too soon, and the card is marked mute when no answer comes within the window. A warm reset pulses reset low again without removing supply or clock.

Clearing the start bit powers the card down in reverse order: reset low, clock stopped, data line driven low, supply off, with a fixed number of reference cycles between steps. The same power-down starts at once, without software, if the card is pulled out or if any of the four fault inputs is raised. An over-current or over-temperature fault while the card is powered also latches a protection flag. The event flags are cleared by a status read, and the mute and early flags are also cleared when a new session starts.

The block is driven by a reference clock. `card_tick` is a one-cycle pulse per card clock period. All inputs are assumed to be already synchronous to `clk`.

Top module: `cas_card_supervisor`

## Requirements
- R1: After reset, with the card present and no fault raised, a 0-to-1 transition of `start_req` sets `vcc_en` on the next clock edge. `io_en` follows `STEP_CYC` clocks later, and `clk_en` follows `STEP_CYC` clocks after that, while `card_rst` stays low.
- R2: During activation, `card_rst` goes high on the clock edge that carries the `HOLD_CYC`-th `card_tick` counted after `clk_en` went high.
- R3: The answer is the first 1-to-0 change of `card_io` after `card_rst` rises. If fewer than `EARLY_CYC` ticks have passed since the rise when the answer is seen, `early_flag` is set; otherwise it is not.
- R4: If `MUTE_CYC` ticks pass after the `card_rst` rise with no answer, `mute_flag` is set. An answer seen on the same edge as the last tick takes precedence.
- R5: While a session is running after its answer window, a 0-to-1 transition of `warm_req` drops `card_rst` for `HOLD_CYC` ticks while `vcc_en` and `clk_en` stay high. The answer timing of R3/R4 then applies again. `warm_done` pulses for one cycle when that answer or mute verdict is reached.
- R6: Clearing `start_req` during a session drops `card_rst` on the next edge. `clk_en` drops `STEP_CYC` clocks later, `io_en` another `STEP_CYC` clocks later, and `vcc_en` another `STEP_CYC` clocks later.
- R7: Card removal (`card_present` low) or any of `flt_vdd`, `flt_vcc`, `flt_ocur`, `flt_temp` during a session causes the same power-down as R6 with the same timing.
- R8: `flt_ocur` or `flt_temp` while `vcc_en` is high sets `prot_flag`. `flt_vdd` and `flt_vcc` do not set it. `prot_flag` holds until a status read.
- R9: A one-cycle `status_rd` clears `mute_flag`, `early_flag` and `prot_flag` on the next edge. The start of a new session also clears `mute_flag` and `early_flag`. A flag being set on the same edge wins over its clear.
- R10: A start request made while the card is absent or a fault is raised is refused, and `vcc_en` stays low. Later removing the blocking condition does not power the card until `start_req` rises again.
- R11: `active` is high exactly while `vcc_en` is high.
- R12: While `rst_n` is low, and right after it is released, all card-side outputs and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Start/stop bit: rise starts a session, low ends it |
| warm_req | input | 1 | Warm reset request bit |
| status_rd | input | 1 | One-cycle pulse: status was read, clears event flags |
| card_present | input | 1 | Card presence, high when inserted |
| flt_vdd | input | 1 | Digital supply fault |
| flt_vcc | input | 1 | Card supply fault |
| flt_ocur | input | 1 | Card over-current fault |
| flt_temp | input | 1 | Over-temperature fault |
| card_io | input | 1 | Level of the card data line |
| card_tick | input | 1 | One pulse per card clock period |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card data line enable (low drives the line low) |
| clk_en | output | 1 | Card clock enable (low stops the clock low) |
| card_rst | output | 1 | Card reset line |
| active | output | 1 | Card supply on |
| mute_flag | output | 1 | No answer within the window |
| early_flag | output | 1 | Answer came too soon |
| prot_flag | output | 1 | Over-current or over-temperature seen in session |
| warm_done | output | 1 | Strobe: warm reset answer or mute reached |

## Verification
The assertions check the ordering invariants on every cycle: data enable never without supply, clock never without data enable, and reset never high without clock. They also check that removal or a fault pulls reset low on the next edge, that nothing powers up while the card is absent, that the answer window counter stays inside its bound, and that flags behave as set-dominant, read-cleared state. The cycle distances between power-up and power-down steps, the hold counted in irregular card ticks, and the early and mute classification at its exact boundaries can only be shown by the bench. The bench's scenarios also cover warm reset, the cause-dependent protection flag and refused starts.

// File: rtl/cas_pkg.sv
// Shared types for the card activation supervisor.
package cas_pkg;

    // Sequencer states: idle, three power-up steps, answer window,
    // running session, warm reset hold, three power-down steps.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_IOEN,
        ST_CLKON,
        ST_ATR,
        ST_RUN,
        ST_WARM,
        ST_DRST,
        ST_DCLK,
        ST_DIO
    } seq_state_e;

endpackage

// File: rtl/cas_atr_mon.sv
// Answer-to-reset monitor.
// Counts card clock ticks while the answer window is armed. Reports an
// answer on the first falling edge of the card data line, and flags it as
// early when it arrives below EARLY_CYC ticks. Reports mute once MUTE_CYC
// ticks pass without an answer.
// Assumes: card_io and card_tick are synchronous to clk; arm stays high
// from the reset release until the cycle a verdict is reported.
module cas_atr_mon #(
    parameter int unsigned EARLY_CYC = 400,
    parameter int unsigned MUTE_CYC  = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic card_tick,
    input  logic card_io,
    output logic answer,
    output logic early,
    output logic mute_hit
);
    localparam int unsigned CW = $clog2(MUTE_CYC + 1);

    logic          io_q;
    logic          io_fall;
    logic [CW-1:0] tcnt;

    // Previous level of the data line, for edge detection (idles high).
    always_ff @(posedge clk) begin
        if (!rst_n) io_q <= 1'b1;
        else        io_q <= card_io;
    end

    // Tick counter for the open window, cleared whenever the window is closed.
    always_ff @(posedge clk) begin
        if (!rst_n)         tcnt <= '0;
        else if (!arm)      tcnt <= '0;
        else if (card_tick) tcnt <= tcnt + CW'(1);
    end

    // Verdicts: an answer wins over a mute reached on the same edge.
    always_comb begin
        io_fall  = io_q && !card_io;
        answer   = arm && io_fall;
        early    = answer && (tcnt < CW'(EARLY_CYC));
        mute_hit = arm && !io_fall && card_tick && (tcnt == CW'(MUTE_CYC - 1));
    end

    AST_ATR_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (tcnt < CW'(MUTE_CYC))); // R4
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(answer && mute_hit)); // R4

endmodule

// File: rtl/cas_evt_flags.sv
// Event flag store.
// Holds the mute, early and protection flags. Each flag is set-dominant.
// A status read clears all three. A new session clears mute and early.
// Assumes: set inputs are single-cycle pulses or levels from the sequencer.
module cas_evt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic sess_start,
    input  logic status_rd,
    input  logic mute_set,
    input  logic early_set,
    input  logic prot_set,
    output logic mute_flag,
    output logic early_flag,
    output logic prot_flag
);
    // Answer timing flags: set on verdict, cleared by read or new session.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_flag  <= 1'b0;
            early_flag <= 1'b0;
        end else begin
            if (mute_set)                     mute_flag  <= 1'b1;
            else if (status_rd || sess_start) mute_flag  <= 1'b0;
            if (early_set)                    early_flag <= 1'b1;
            else if (status_rd || sess_start) early_flag <= 1'b0;
        end
    end

    // Protection flag: set by a thermal or current fault, cleared by read only.
    always_ff @(posedge clk) begin
        if (!rst_n)         prot_flag <= 1'b0;
        else if (prot_set)  prot_flag <= 1'b1;
        else if (status_rd) prot_flag <= 1'b0;
    end

    AST_READ_CLEARS_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !mute_set) |=> !mute_flag); // R9
    AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_flag && !status_rd) |=> prot_flag); // R8

endmodule

// File: rtl/cas_seq.sv
// Activation / deactivation sequencer.
// Steps the card supply, data enable, clock and reset through the power-up
// order on a start edge, holds reset low for HOLD_CYC card ticks on cold and
// warm resets, and walks the power-down order with STEP_CYC reference clocks
// between steps. Power-down is forced on stop, removal or fault.
// Assumes: inputs synchronous to clk; answer/mute_hit only while arm is high.
module cas_seq
    import cas_pkg::*;
#(
    parameter int unsigned STEP_CYC = 8,
    parameter int unsigned HOLD_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic warm_req,
    input  logic card_present,
    input  logic fault_any,
    input  logic card_tick,
    input  logic answer,
    input  logic mute_hit,
    output logic vcc_en,
    output logic io_en,
    output logic clk_en,
    output logic card_rst,
    output logic arm,
    output logic sess_start,
    output logic warm_done
);
    localparam int unsigned CNT_MAX = (STEP_CYC > HOLD_CYC) ? STEP_CYC : HOLD_CYC;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          start_q, warm_q, warm_sess;
    logic          live, abort, step_done, hold_done, start_rise, warm_rise;

    // Request edge history, so held request bits act only once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            warm_q  <= 1'b0;
        end else begin
            start_q <= start_req;
            warm_q  <= warm_req;
        end
    end

    // Decode of edges, the abort condition and counter terminal values.
    always_comb begin
        live       = state inside {ST_PWR, ST_IOEN, ST_CLKON, ST_ATR, ST_RUN, ST_WARM};
        abort      = live && (!start_req || !card_present || fault_any);
        start_rise = start_req && !start_q;
        warm_rise  = warm_req && !warm_q;
        step_done  = (cnt == CW'(STEP_CYC - 1));
        hold_done  = card_tick && (cnt == CW'(HOLD_CYC - 1));
        sess_start = (state == ST_IDLE) && start_rise && card_present && !fault_any;
        arm        = (state == ST_ATR);
    end

    // State walk; each card line changes only on entry to the step that owns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            vcc_en    <= 1'b0;
            io_en     <= 1'b0;
            clk_en    <= 1'b0;
            card_rst  <= 1'b0;
            warm_sess <= 1'b0;
            warm_done <= 1'b0;
        end else begin
            warm_done <= 1'b0;
            if (abort) begin
                state     <= ST_DRST;
                card_rst  <= 1'b0;
                cnt       <= '0;
                warm_sess <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: if (sess_start) begin
                        state  <= ST_PWR;
                        vcc_en <= 1'b1;
                        cnt    <= '0;
                    end
                    ST_PWR: if (step_done) begin
                        state <= ST_IOEN;
                        io_en <= 1'b1;
                        cnt   <= '0;
                    end else cnt <= cnt + CW'(1);
                    ST_IOEN: if (step_done) begin
                        state  <= ST_CLKON;
                        clk_en <= 1'b1;
                        cnt    <= '0;
                    end else cnt <= cnt + CW'(1);
                    ST_CLKON, ST_WARM: if (hold_done) begin
                        state    <= ST_ATR;
                        card_rst <= 1'b1;
                        cnt      <= '0;
                    end else if (card_tick) cnt <= cnt + CW'(1);
                    ST_ATR: if (answer || mute_hit) begin
                        state     <= ST_RUN;
                        warm_done <= warm_sess;
                        warm_sess <= 1'b0;
                    end
                    ST_RUN: if (warm_rise) begin
                        state     <= ST_WARM;
                        card_rst  <= 1'b0;
                        cnt       <= '0;
                        warm_sess <= 1'b1;
                    end
                    ST_DRST: if (step_done) begin
                        state  <= ST_DCLK;
                        clk_en <= 1'b0;
                        cnt    <= '0;
                    end else cnt <= cnt + CW'(1);
                    ST_DCLK: if (step_done) begin
                        state <= ST_DIO;
                        io_en <= 1'b0;
                        cnt   <= '0;
                    end else cnt <= cnt + CW'(1);
                    ST_DIO: if (step_done) begin
                        state  <= ST_IDLE;
                        vcc_en <= 1'b0;
                        cnt    <= '0;
                    end else cnt <= cnt + CW'(1);
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> vcc_en); // R1
    AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> io_en); // R6
    AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> clk_en); // R2
    AST_FAULT_DROPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_en && (fault_any || !card_present)) |=> !card_rst); // R7
    AST_NO_POWER_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_en && !card_present) |=> !vcc_en); // R10

endmodule

// File: rtl/cas_card_supervisor.sv
// Card activation and answer-to-reset supervisor (top).
// Joins the sequencer, the answer monitor and the event flags. Faults are
// merged here, and the protection event is qualified by card supply.
// Assumes: all inputs synchronous to clk; card_tick is a one-cycle pulse
// per card clock period; reset is synchronous and active low.
module cas_card_supervisor #(
    parameter int unsigned STEP_CYC  = 8,
    parameter int unsigned HOLD_CYC  = 400,
    parameter int unsigned EARLY_CYC = 400,
    parameter int unsigned MUTE_CYC  = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic warm_req,
    input  logic status_rd,
    input  logic card_present,
    input  logic flt_vdd,
    input  logic flt_vcc,
    input  logic flt_ocur,
    input  logic flt_temp,
    input  logic card_io,
    input  logic card_tick,
    output logic vcc_en,
    output logic io_en,
    output logic clk_en,
    output logic card_rst,
    output logic active,
    output logic mute_flag,
    output logic early_flag,
    output logic prot_flag,
    output logic warm_done
);
    logic fault_any, prot_evt, arm, sess_start, answer, early, mute_hit;

    // Fault merge and supply-qualified protection event.
    always_comb begin
        fault_any = flt_vdd || flt_vcc || flt_ocur || flt_temp;
        prot_evt  = vcc_en && (flt_ocur || flt_temp);
        active    = vcc_en;
    end

    cas_seq #(
        .STEP_CYC (STEP_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .warm_req     (warm_req),
        .card_present (card_present),
        .fault_any    (fault_any),
        .card_tick    (card_tick),
        .answer       (answer),
        .mute_hit     (mute_hit),
        .vcc_en       (vcc_en),
        .io_en        (io_en),
        .clk_en       (clk_en),
        .card_rst     (card_rst),
        .arm          (arm),
        .sess_start   (sess_start),
        .warm_done    (warm_done)
    );

    cas_atr_mon #(
        .EARLY_CYC (EARLY_CYC),
        .MUTE_CYC  (MUTE_CYC)
    ) u_atr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .card_tick (card_tick),
        .card_io   (card_io),
        .answer    (answer),
        .early     (early),
        .mute_hit  (mute_hit)
    );

    cas_evt_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .sess_start (sess_start),
        .status_rd  (status_rd),
        .mute_set   (mute_hit),
        .early_set  (early),
        .prot_set   (prot_evt),
        .mute_flag  (mute_flag),
        .early_flag (early_flag),
        .prot_flag  (prot_flag)
    );

    AST_PROT_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_flag && !vcc_en) |=> !prot_flag); // R8

endmodule

// File: tb/sim_cas_card_supervisor.sv
// Bench: directed corners plus seeded random answer times, card tick
// density and power-down causes, checked against values derived from the
// requirements.
module sim_cas_card_supervisor;
    localparam int STEP  = 3;
    localparam int HOLD  = 10;
    localparam int EARLY = 10;
    localparam int MUTE  = 120;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, warm_req = 1'b0, status_rd = 1'b0;
    logic card_present = 1'b1, flt_vdd = 1'b0, flt_vcc = 1'b0;
    logic flt_ocur = 1'b0, flt_temp = 1'b0, card_io = 1'b1, card_tick = 1'b0;
    logic vcc_en, io_en, clk_en, card_rst, active;
    logic mute_flag, early_flag, prot_flag, warm_done;

    always #5 clk = ~clk;

    cas_card_supervisor #(
        .STEP_CYC (STEP), .HOLD_CYC (HOLD), .EARLY_CYC (EARLY), .MUTE_CYC (MUTE)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start_req (start_req), .warm_req (warm_req),
        .status_rd (status_rd), .card_present (card_present), .flt_vdd (flt_vdd),
        .flt_vcc (flt_vcc), .flt_ocur (flt_ocur), .flt_temp (flt_temp),
        .card_io (card_io), .card_tick (card_tick), .vcc_en (vcc_en),
        .io_en (io_en), .clk_en (clk_en), .card_rst (card_rst), .active (active),
        .mute_flag (mute_flag), .early_flag (early_flag), .prot_flag (prot_flag),
        .warm_done (warm_done)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int hold_ticks = 0, atr_ticks = 0, hold_at_rise = 0;
    int t_vcc_on = 0, t_io_on = 0, t_clk_on = 0;
    int t_rst_off = 0, t_clk_off = 0, t_io_off = 0, t_vcc_off = 0;
    bit p_vcc = 0, p_io = 0, p_clk = 0, p_rst = 0, warm_seen = 0;

    // Observer at the falling edge: records step times and ticks the design saw.
    always @(negedge clk) begin
        cyc++;
        if (p_clk && !p_rst) hold_ticks += int'(card_tick); else hold_ticks = 0;
        if (!p_rst) atr_ticks = 0;
        else if (card_io) atr_ticks += int'(card_tick);
        if (!p_vcc && vcc_en) t_vcc_on = cyc;
        if (!p_io && io_en) t_io_on = cyc;
        if (!p_clk && clk_en) t_clk_on = cyc;
        if (!p_rst && card_rst) hold_at_rise = hold_ticks;
        if (p_rst && !card_rst) t_rst_off = cyc;
        if (p_clk && !clk_en) t_clk_off = cyc;
        if (p_io && !io_en) t_io_off = cyc;
        if (p_vcc && !vcc_en) t_vcc_off = cyc;
        if (warm_done) warm_seen = 1;
        p_vcc = vcc_en; p_io = io_en; p_clk = clk_en; p_rst = card_rst;
        card_tick <= rst_n && (($urandom % 4) != 0);
    end

    function automatic bit exp_early(int n); return n < EARLY; endfunction
    function automatic bit exp_mute(int n);  return n >= MUTE; endfunction
    function automatic bit exp_prot(int cause); return cause == 4 || cause == 5; endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_level(ref logic sig, input logic lvl);
        for (int g = 0; g < 2000; g++) begin
            if (sig === lvl) return;
            step(1);
        end
        check_eq("wait timeout", int'(sig), int'(lvl));
    endtask

    task automatic rd_status();
        status_rd = 1'b1; step(1); status_rd = 1'b0; step(1);
    endtask

    // Power-up with checks of step spacing and reset hold (R1, R2, R9, R11).
    task automatic activate();
        int t0;
        start_req = 1'b0; step(2);
        start_req = 1'b1; t0 = cyc;
        wait_level(card_rst, 1'b1);
        check_eq("R1 vcc_en step", t_vcc_on, t0 + 1);
        check_eq("R1 io_en step", t_io_on, t0 + 1 + STEP);
        check_eq("R1 clk_en step", t_clk_on, t0 + 1 + 2 * STEP);
        check_eq("R2 reset hold ticks", hold_at_rise, HOLD);
        check_eq("R9 session clears mute/early", int'(mute_flag || early_flag), 0);
        check_eq("R11 active", int'(active), 1);
    endtask

    // Answer window: drop the data line after target ticks (R3, R4, R5).
    task automatic atr(input int target, input bit warm);
        for (int g = 0; g < 2000; g++) begin
            if (mute_flag) break;
            if (atr_ticks == target) begin card_io = 1'b0; break; end
            step(1);
        end
        step(3);
        card_io = 1'b1;
        check_eq($sformatf("R3 early_flag target=%0d", target), int'(early_flag), int'(exp_early(target)));
        check_eq($sformatf("R4 mute_flag target=%0d", target), int'(mute_flag), int'(exp_mute(target)));
        if (warm) check_eq("R5 warm_done strobe", int'(warm_seen), 1);
    endtask

    task automatic warm(input int target);
        rd_status();
        check_eq("R9 read clears flags", int'(mute_flag || early_flag), 0);
        warm_seen = 0;
        warm_req = 1'b1;
        wait_level(card_rst, 1'b0);
        check_eq("R5 power kept at warm start", int'(vcc_en && clk_en), 1);
        wait_level(card_rst, 1'b1);
        check_eq("R5 warm hold ticks", hold_at_rise, HOLD);
        check_eq("R5 power kept at warm end", int'(vcc_en && clk_en), 1);
        atr(target, 1'b1);
        warm_req = 1'b0;
        step(2);
    endtask

    // Power-down by cause: 0 stop, 1 removal, 2..5 faults (R6, R7, R8).
    task automatic deactivate(input int cause);
        int t0;
        string rq;
        rq = (cause == 0) ? "R6" : "R7";
        case (cause)
            0: start_req = 1'b0;
            1: card_present = 1'b0;
            2: flt_vdd = 1'b1;
            3: flt_vcc = 1'b1;
            4: flt_ocur = 1'b1;
            default: flt_temp = 1'b1;
        endcase
        t0 = cyc;
        wait_level(vcc_en, 1'b0);
        check_eq({rq, " rst low"}, t_rst_off, t0 + 1);
        check_eq({rq, " clk stop"}, t_clk_off, t0 + 1 + STEP);
        check_eq({rq, " io low"}, t_io_off, t0 + 1 + 2 * STEP);
        check_eq({rq, " vcc off"}, t_vcc_off, t0 + 1 + 3 * STEP);
        check_eq("R11 inactive", int'(active), 0);
        check_eq($sformatf("R8 prot cause=%0d", cause), int'(prot_flag), int'(exp_prot(cause)));
        card_present = 1'b1; flt_vdd = 1'b0; flt_vcc = 1'b0;
        flt_ocur = 1'b0; flt_temp = 1'b0; start_req = 1'b0;
        step(2);
        rd_status();
        check_eq("R9 read clears prot", int'(prot_flag), 0);
    endtask

    initial begin
        int targets[6];
        void'($urandom(32'd20240611));
        targets[0] = 0; targets[1] = EARLY - 1; targets[2] = EARLY;
        targets[3] = MUTE - 1; targets[4] = MUTE; targets[5] = MUTE + 5;
        step(3);
        check_eq("R12 outputs in reset", int'({vcc_en, io_en, clk_en, card_rst, active}), 0);
        rst_n = 1'b1;
        step(2);
        check_eq("R12 outputs after reset", int'({vcc_en, io_en, clk_en, card_rst, mute_flag, early_flag, prot_flag}), 0);

        // Refused starts (R10).
        card_present = 1'b0; start_req = 1'b1; step(20);
        check_eq("R10 refused when absent", int'(vcc_en), 0);
        card_present = 1'b1; step(20);
        check_eq("R10 no retry without new edge", int'(vcc_en), 0);
        start_req = 1'b0; flt_vcc = 1'b1; step(2); start_req = 1'b1; step(20);
        check_eq("R10 refused on fault", int'(vcc_en), 0);
        check_eq("R8 no prot while unpowered", int'(prot_flag), 0);
        flt_vcc = 1'b0; start_req = 1'b0; step(2);

        for (int it = 0; it < 14; it++) begin
            int tgt;
            tgt = (it < 6) ? targets[it] : int'($urandom % (MUTE + 20));
            activate();
            atr(tgt, 1'b0);
            if (it % 2 == 1) warm(int'($urandom % (MUTE + 20)));
            if (it == 2) warm(EARLY - 1);
            deactivate(it % 6);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule